// File: doc/BRIEF.md
# Timed Deferred-Increment Queue

This block keeps a small pool of pending additions. Each addition names one of several counter registers, carries a signed amount, and is due some number of cycles in the future. A free-running cycle count, started at reset, is the time base. When an addition is accepted, the block turns its relative delay into an absolute due time by adding the delay to the cycle count of that moment. On every clock edge, each held entry whose due time has been reached is added into its counter and its slot is released.

A client posts an addition with a one-cycle strobe on the schedule port. It reads any counter through a combinational read port, and it watches occupancy through the full, empty and pending-count outputs. An attempt to post while all slots are taken is discarded and raises a sticky overflow flag. Several entries may mature on the same edge; the block applies all of them together, including several aimed at one counter.

Top module: `dq_timed_adder`

## Requirements
- R1: After reset every counter reads 0, empty is 1, full is 0, the pending count is 0 and the overflow flag is 0.
- R2: An addition accepted on the clock edge where the cycle count is T, with delay d of 1 or more, changes its counter on the edge where the count reaches T+d. That is the d-th edge after acceptance, and the counter does not change before it.
- R3: An addition accepted with delay 0 is applied on the very next clock edge, the same edge as delay 1.
- R4: The 16-bit increment is sign-extended to 32 bits and added modulo 2^32, so negative amounts lower a counter and the counter wraps through zero.
- R5: When several due entries target the same counter on one edge, their sum is added to it on that edge.
- R6: An applied entry is released on the edge that applies it, and the pending count drops by the number applied. Entries that are not yet due stay pending and unchanged, and counters with no due entry hold their value.
- R7: There are 8 slots and full is 1 when all of them are occupied. A posting while full is discarded, leaves every counter unaffected, and sets the overflow flag, which stays 1 until reset.
- R8: When a posting is accepted on the same edge that entries are applied, the new pending count equals the old count, minus the number applied, plus one.
- R9: rd_value shows the counter selected by rd_idx with no clock delay. The counter index is 2 bits, giving counters 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sched_valid | input | 1 | Posts one addition on this edge |
| sched_idx | input | 2 | Target counter of the posting |
| sched_inc | input | 16 | Signed increment |
| sched_delay | input | 16 | Unsigned delay in cycles |
| rd_idx | input | 2 | Counter selected for reading |
| rd_value | output | 32 | Value of the selected counter |
| full | output | 1 | All slots occupied |
| empty | output | 1 | No slot occupied |
| pending_count | output | 4 | Number of occupied slots |
| overflow | output | 1 | Sticky: a posting was discarded |

## Verification
The bench tests the exact edge on which an addition lands, for both a longer delay and delay zero. A design that is off by one in its due-time comparison would show the counter change one cycle early or late. It stacks three entries that mature together on one counter, which catches a design that applies only one due entry per edge or lets one overwrite another in the sum. It fills every slot and posts once more, which exposes a design that accepts into an occupied slot, forgets the overflow flag, or lets the discarded amount reach a counter. It also posts on the same edge as an application, to catch miscounting of the pending total. Negative increments that cross zero catch a missing sign extension.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int CTR_W  = 32;
  localparam int INC_W  = 16;
  localparam int DLY_W  = 16;
  localparam int TIME_W = 32;

  // absolute due time from the current count and a relative delay
  function automatic logic [TIME_W-1:0] due_time(input logic [TIME_W-1:0] now,
                                                 input logic [DLY_W-1:0]  dly);
    return now + TIME_W'(dly);
  endfunction

  // wrap-safe "due <= now": the signed distance is not negative
  function automatic logic is_due(input logic [TIME_W-1:0] now,
                                  input logic [TIME_W-1:0] due);
    logic [TIME_W-1:0] diff;
    diff = now - due;
    return ~diff[TIME_W-1];
  endfunction

  // sign extension of an increment to counter width
  function automatic logic [CTR_W-1:0] widen_inc(input logic [INC_W-1:0] inc);
    return {{(CTR_W-INC_W){inc[INC_W-1]}}, inc};
  endfunction
endpackage

// File: rtl/dq_slot_alloc.sv
module dq_slot_alloc #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DEPTH-1:0] valid_mask,
  output logic [DEPTH-1:0] grant,
  output logic             full
);
  logic found;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_mask[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign full = &valid_mask;

  // R7: at most one slot is offered to a new posting
  assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

// File: rtl/dq_entry_array.sv
module dq_entry_array
  import dq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int IDX_W = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TIME_W-1:0]           now,
  input  logic                        wr_en,
  input  logic [DEPTH-1:0]            wr_grant,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [INC_W-1:0]            wr_inc,
  input  logic [DLY_W-1:0]            wr_delay,
  output logic [DEPTH-1:0]            valid_mask,
  output logic [DEPTH-1:0]            due_mask,
  output logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
  output logic [DEPTH-1:0][INC_W-1:0] ent_inc,
  output logic [CW-1:0]               n_valid,
  output logic [CW-1:0]               n_due
);
  logic [DEPTH-1:0][TIME_W-1:0] ent_due;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign due_mask[i] = valid_mask[i] & is_due(now, ent_due[i]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_mask[i] <= 1'b0;
        ent_idx[i]    <= '0;
        ent_inc[i]    <= '0;
        ent_due[i]    <= '0;
      end else if (wr_en && wr_grant[i]) begin
        valid_mask[i] <= 1'b1;
        ent_idx[i]    <= wr_idx;
        ent_inc[i]    <= wr_inc;
        ent_due[i]    <= due_time(now, wr_delay);
      end else if (due_mask[i]) begin
        valid_mask[i] <= 1'b0;
      end
    end

    // R6: an applied entry is released on the edge that applies it
    assert_due_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      due_mask[i] |=> !valid_mask[i]);
    // R6: an entry not yet due keeps its stored contents
    assert_wait_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_mask[i] && !due_mask[i]) |=>
        (valid_mask[i] && $stable(ent_due[i]) && $stable(ent_inc[i]) && $stable(ent_idx[i])));
  end

  always_comb begin
    n_valid = '0;
    n_due   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      n_valid = n_valid + {{(CW-1){1'b0}}, valid_mask[i]};
      n_due   = n_due   + {{(CW-1){1'b0}}, due_mask[i]};
    end
  end
endmodule

// File: rtl/dq_counter_bank.sv
module dq_counter_bank
  import dq_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int DEPTH   = 8,
  parameter int IDX_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DEPTH-1:0]            due_mask,
  input  logic [DEPTH-1:0][IDX_W-1:0] ent_idx,
  input  logic [DEPTH-1:0][INC_W-1:0] ent_inc,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [CTR_W-1:0]            rd_value
);
  logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
  logic [NUM_CTR-1:0][CTR_W-1:0] add_sum;
  logic [NUM_CTR-1:0]            hit;

  for (genvar c = 0; c < NUM_CTR; c++) begin : g_ctr
    always_comb begin
      add_sum[c] = '0;
      hit[c]     = 1'b0;
      for (int e = 0; e < DEPTH; e++) begin
        if (due_mask[e] && (ent_idx[e] == IDX_W'(c))) begin
          add_sum[c] = add_sum[c] + widen_inc(ent_inc[e]);
          hit[c]     = 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ctr_q[c] <= '0;
      else        ctr_q[c] <= ctr_q[c] + add_sum[c];
    end

    // R6: a counter without a due entry holds its value
    assert_ctr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit[c] |=> $stable(ctr_q[c]));
  end

  assign rd_value = (int'(rd_idx) < NUM_CTR) ? ctr_q[rd_idx] : '0;
endmodule

// File: rtl/dq_timed_adder.sv
module dq_timed_adder
  import dq_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int DEPTH   = 8,
  localparam int IDX_W  = $clog2(NUM_CTR),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sched_valid,
  input  logic [IDX_W-1:0]    sched_idx,
  input  logic [INC_W-1:0]    sched_inc,
  input  logic [DLY_W-1:0]    sched_delay,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [CTR_W-1:0]    rd_value,
  output logic                full,
  output logic                empty,
  output logic [CW-1:0]       pending_count,
  output logic                overflow
);
  logic [TIME_W-1:0]           now_q;
  logic [DEPTH-1:0]            valid_mask, due_mask, grant;
  logic [DEPTH-1:0][IDX_W-1:0] ent_idx;
  logic [DEPTH-1:0][INC_W-1:0] ent_inc;
  logic [CW-1:0]               n_valid, n_due;
  logic                        accept, reject;

  assign accept = sched_valid & ~full;
  assign reject = sched_valid & full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      now_q    <= '0;
      overflow <= 1'b0;
    end else begin
      now_q <= now_q + 1'b1;
      if (reject) overflow <= 1'b1;
    end
  end

  dq_slot_alloc #(.DEPTH(DEPTH)) u_alloc (
    .clk(clk), .rst_n(rst_n), .valid_mask(valid_mask), .grant(grant), .full(full)
  );

  dq_entry_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .now(now_q),
    .wr_en(accept), .wr_grant(grant), .wr_idx(sched_idx),
    .wr_inc(sched_inc), .wr_delay(sched_delay),
    .valid_mask(valid_mask), .due_mask(due_mask),
    .ent_idx(ent_idx), .ent_inc(ent_inc),
    .n_valid(n_valid), .n_due(n_due)
  );

  dq_counter_bank #(.NUM_CTR(NUM_CTR), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_ctrs (
    .clk(clk), .rst_n(rst_n), .due_mask(due_mask),
    .ent_idx(ent_idx), .ent_inc(ent_inc),
    .rd_idx(rd_idx), .rd_value(rd_value)
  );

  assign pending_count = n_valid;
  assign empty         = (n_valid == '0);

  // R6, R8: occupancy moves by accepted postings minus applied entries
  assert_pending_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pending_count == $past(pending_count) - $past(n_due) + CW'($past(accept)));
  // R7: a posting while full raises the flag
  assert_drop_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sched_valid && full) |=> overflow);
  // R7: the flag is sticky
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R1: full and empty are never both asserted
  assert_full_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({full, empty}));
endmodule

// File: tb/test_dq_timed_adder.sv
`timescale 1ns/1ps
module test_dq_timed_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sched_valid = 1'b0;
  logic [1:0]  sched_idx = '0;
  logic [15:0] sched_inc = '0;
  logic [15:0] sched_delay = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_value;
  logic        full, empty, overflow;
  logic [3:0]  pending_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dq_timed_adder i_dq_timed_adder (
    .clk(clk), .rst_n(rst_n), .sched_valid(sched_valid), .sched_idx(sched_idx),
    .sched_inc(sched_inc), .sched_delay(sched_delay), .rd_idx(rd_idx),
    .rd_value(rd_value), .full(full), .empty(empty),
    .pending_count(pending_count), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] idx, output logic [31:0] v);
    rd_idx = idx;
    #1;
    v = rd_value;
  endtask

  task automatic chk_ctr(input string tag, input logic [1:0] idx, input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, v);
    chk(tag, v, exp);
  endtask

  // one posting across exactly one edge; returns at the following falling edge
  task automatic post(input logic [1:0] idx, input logic [15:0] inc, input logic [15:0] dly);
    sched_valid = 1'b1; sched_idx = idx; sched_inc = inc; sched_delay = dly;
    @(negedge clk);
    sched_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset();
    do_reset();
    for (int c = 0; c < 4; c++) chk_ctr("R1 counter", 2'(c), 32'd0);
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 pending", 32'(pending_count), 32'd0);
    chk("R1 overflow", 32'(overflow), 32'd0);
  endtask

  task automatic t_delay();
    post(2'd1, 16'd5, 16'd3);
    idle(2);
    chk_ctr("R2 before due", 2'd1, 32'd0);
    chk("R2 pending held", 32'(pending_count), 32'd1);
    idle(1);
    chk_ctr("R2 on due edge", 2'd1, 32'd5);
    chk("R6 freed", 32'(pending_count), 32'd0);
  endtask

  task automatic t_zero();
    post(2'd2, 16'd7, 16'd0);
    chk("R3 accepted", 32'(pending_count), 32'd1);
    chk_ctr("R3 not yet", 2'd2, 32'd0);
    idle(1);
    chk_ctr("R3 next edge", 2'd2, 32'd7);
    chk("R3 freed", 32'(empty), 32'd1);
  endtask

  task automatic t_negative();
    post(2'd0, 16'hFFFD, 16'd1);
    idle(1);
    chk_ctr("R4 below zero", 2'd0, 32'hFFFF_FFFD);
    post(2'd0, 16'd3, 16'd1);
    idle(1);
    chk_ctr("R4 wrap to zero", 2'd0, 32'd0);
  endtask

  task automatic t_same();
    post(2'd3, 16'd10, 16'd4);
    post(2'd3, 16'd20, 16'd3);
    post(2'd3, 16'hFFFB, 16'd2);
    chk("R5 three pending", 32'(pending_count), 32'd3);
    idle(1);
    chk_ctr("R5 none yet", 2'd3, 32'd0);
    idle(1);
    chk_ctr("R5 summed", 2'd3, 32'd25);
    chk("R6 all freed", 32'(pending_count), 32'd0);
  endtask

  task automatic t_partial();
    post(2'd1, 16'd1, 16'd2);
    post(2'd1, 16'd100, 16'd10);
    idle(1);
    chk_ctr("R6 first applied", 2'd1, 32'd6);
    chk("R6 one left", 32'(pending_count), 32'd1);
    idle(8);
    chk_ctr("R6 second waits", 2'd1, 32'd6);
    chk_ctr("R9 other counter", 2'd3, 32'd25);
    idle(1);
    chk_ctr("R6 second applied", 2'd1, 32'd106);
    chk("R6 empty", 32'(empty), 32'd1);
  endtask

  task automatic t_simul();
    post(2'd0, 16'd2, 16'd1);
    post(2'd0, 16'd4, 16'd5);
    chk_ctr("R8 first applied", 2'd0, 32'd2);
    chk("R8 pending", 32'(pending_count), 32'd1);
    idle(4);
    chk_ctr("R8 second waits", 2'd0, 32'd2);
    idle(1);
    chk_ctr("R8 second applied", 2'd0, 32'd6);
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) post(2'd2, 16'd1, 16'd1000);
    chk("R7 full", 32'(full), 32'd1);
    chk("R7 pending 8", 32'(pending_count), 32'd8);
    chk("R7 no overflow yet", 32'(overflow), 32'd0);
    post(2'd2, 16'd50, 16'd0);
    chk("R7 overflow set", 32'(overflow), 32'd1);
    chk("R7 still 8", 32'(pending_count), 32'd8);
    idle(1010);
    chk_ctr("R7 dropped not applied", 2'd2, 32'd15);
    chk("R7 drained", 32'(empty), 32'd1);
    chk("R7 overflow sticky", 32'(overflow), 32'd1);
    do_reset();
    chk("R1 overflow cleared", 32'(overflow), 32'd0);
  endtask

  initial begin
    t_reset();
    t_delay();
    t_zero();
    t_negative();
    t_same();
    t_partial();
    t_simul();
    t_full();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule